// File: doc/BRIEF.md
# Biphase Infrared Frame Transmitter

This block turns a latched system number and command number into a serial infrared code frame. A frame holds fourteen bits: two start bits at logic 1, a toggle (control) bit, the system field and then the command field, each field sent most significant bit first. Each bit is biphase coded: it occupies one bit-time, split into two equal halves of opposite level. The block drives the coded level on a baseband data pin. It also drives the same level gated by a carrier on a modulated pin. The carrier runs at one twelfth of the clock with a 25% duty cycle.

A key scanner raises `code_valid` for one cycle when a legal key has been decoded, and holds `key_held` while the key stays down. Frames repeat at a fixed period while the key is held. The system and command inputs are sampled again at the start of every repeat. A frame that has started always runs to its last half-bit. The toggle bit flips each time the block returns to idle after a frame, so a receiver can tell a new press from a held key. When idle, both output enables are low and the pads float.

The controller is a three-state machine:
- `TX_IDLE`: waiting for a code.
- `TX_SEND`: shifting out the fourteen bits.
- `TX_GAP`: silent remainder of the repeat period.

The transitions are:
- `TX_IDLE`→`TX_SEND` on `code_valid`.
- `TX_SEND`→`TX_GAP` when the last half-bit ends with the key held.
- `TX_SEND`→`TX_IDLE` when the last half-bit ends with the key released.
- `TX_GAP`→`TX_SEND` when the repeat period ends with the key held.
- `TX_GAP`→`TX_IDLE` as soon as the key is seen released.

Top module: `irtx_biphase_tx`

## Requirements
- R1: After reset `busy`, `data_oe`, `mod_oe`, `data_out` and `mod_out` are all 0, and the toggle bit is 0.
- R2: A frame sends 14 bits in this order: 1, 1, toggle, system bits 4..0, command bits 5..0.
- R3: Each bit lasts 2×HALF_CLKS clocks (default 768). Logic 1 is low for the first half and high for the second half; logic 0 is the reverse. `data_out` is 0 outside a frame.
- R4: `mod_out` equals `data_out` AND a carrier. The carrier is high for the first CAR_HIGH (3) of every CAR_DIV (12) clocks, and its count restarts at the start of every half-bit.
- R5: `busy`, `data_oe` and `mod_oe` rise in the cycle after `code_valid` is sampled in `TX_IDLE`. They stay 1 until the block returns to `TX_IDLE`.
- R6: If `key_held` is still 1 when REP_BITS (default 64) bit-times have passed since a frame began, a new frame starts at once. The new frame uses the current `sys_num` and `cmd_num`.
- R7: A frame that has started is completed even if `key_held` falls during it. If the key is released when the last half-bit ends, the block goes to idle.
- R8: In the gap between frames, a low `key_held` returns the block to idle on the next clock.
- R9: The toggle bit is inverted on every return to idle from a frame, and keeps its value between presses.
- R10: `code_valid`, `sys_num` and `cmd_num` have no effect on a frame already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_valid | input | 1 | One-cycle pulse: a legal code is latched |
| key_held | input | 1 | Key still pressed |
| sys_num | input | SYS_W | System number |
| cmd_num | input | CMD_W | Command number |
| data_out | output | 1 | Baseband biphase data |
| data_oe | output | 1 | Output enable for `data_out` |
| mod_out | output | 1 | Carrier-modulated data |
| mod_oe | output | 1 | Output enable for `mod_out` |
| busy | output | 1 | Transmission or repeat gap in progress |

## Verification
`busy` and both enables are due one clock after `code_valid` is sampled. The first half-bit of a frame is visible in that same cycle. Every later half-bit boundary falls exactly HALF_CLKS clocks after the previous one. A release in the gap shows one clock later, and a release during a frame shows only after the fourteenth bit. The bench keeps a behavioural model that counts clocks since the start of the frame and derives every expected output value from that count. It drives inputs on the falling edge and compares all outputs on every falling edge, so each result is judged in the cycle the register chain makes it due.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_t;
endpackage

// File: rtl/irtx_half_timer.sv
module irtx_half_timer #(
    parameter int HALF_CLKS = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half_end = run && (cnt_q == LAST);

    // Half-bit length R3: the count advances by one while running.
    assert_half_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !half_end) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int CAR_DIV  = 12,
    parameter int CAR_HIGH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic phase_hi
);
    localparam int CW = $clog2(CAR_DIV);
    localparam logic [CW-1:0] LAST = CW'(CAR_DIV - 1);
    localparam logic [CW-1:0] HI   = CW'(CAR_HIGH);

    logic [CW-1:0] car_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_q <= '0;
        end else if (restart || car_q == LAST) begin
            car_q <= '0;
        end else begin
            car_q <= car_q + 1'b1;
        end
    end

    assign phase_hi = (car_q < HI);

    // Carrier restart R4: each burst opens with the high phase.
    assert_burst_starts_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> phase_hi);
endmodule

// File: rtl/irtx_biphase_enc.sv
module irtx_biphase_enc #(
    parameter int FRAME_BITS = 14,
    parameter int HW         = 8
) (
    input  logic                  sending,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic [HW-1:0]         hidx,
    output logic                  level
);
    logic [HW-1:0]         bit_n;
    logic [FRAME_BITS-1:0] shifted;
    logic                  cur_bit;

    always_comb begin
        bit_n   = hidx >> 1;
        shifted = frame << bit_n;
        cur_bit = shifted[FRAME_BITS-1];
        if (!sending || hidx == '0) begin
            level = 1'b0;
        end else if (hidx[0]) begin
            level = cur_bit;
        end else begin
            level = ~cur_bit;
        end
    end
endmodule

// File: rtl/irtx_biphase_tx.sv
module irtx_biphase_tx
    import irtx_pkg::*;
#(
    parameter int SYS_W     = 5,
    parameter int CMD_W     = 6,
    parameter int HALF_CLKS = 384,
    parameter int REP_BITS  = 64,
    parameter int CAR_DIV   = 12,
    parameter int CAR_HIGH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic             key_held,
    input  logic [SYS_W-1:0] sys_num,
    input  logic [CMD_W-1:0] cmd_num,
    output logic             data_out,
    output logic             data_oe,
    output logic             mod_out,
    output logic             mod_oe,
    output logic             busy
);
    localparam int FRAME_BITS    = 3 + SYS_W + CMD_W;
    localparam int FRAME_HALVES  = 2 * FRAME_BITS;
    localparam int PERIOD_HALVES = 2 * REP_BITS;
    localparam int HW            = $clog2(PERIOD_HALVES + 1);
    localparam logic [HW-1:0] LAST_FRAME_H  = HW'(FRAME_HALVES - 1);
    localparam logic [HW-1:0] LAST_PERIOD_H = HW'(PERIOD_HALVES - 1);

    tx_state_t             state_q, state_d;
    logic [HW-1:0]         hidx_q, hidx_d;
    logic [FRAME_BITS-1:0] frame_q, frame_d;
    logic                  toggle_q, toggle_d;
    logic                  half_end;
    logic                  car_hi;
    logic                  level;
    logic                  sending;

    irtx_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != TX_IDLE),
        .half_end (half_end)
    );

    irtx_carrier #(.CAR_DIV(CAR_DIV), .CAR_HIGH(CAR_HIGH)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (state_q == TX_IDLE || half_end),
        .phase_hi (car_hi)
    );

    irtx_biphase_enc #(.FRAME_BITS(FRAME_BITS), .HW(HW)) u_enc (
        .sending (sending),
        .frame   (frame_q),
        .hidx    (hidx_q),
        .level   (level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            hidx_q   <= '0;
            frame_q  <= '0;
            toggle_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            hidx_q   <= hidx_d;
            frame_q  <= frame_d;
            toggle_q <= toggle_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        hidx_d   = hidx_q;
        frame_d  = frame_q;
        toggle_d = toggle_q;
        unique case (state_q)
            TX_IDLE: begin
                if (code_valid) begin
                    state_d = TX_SEND;
                    hidx_d  = '0;
                    frame_d = {2'b11, toggle_q, sys_num, cmd_num};
                end
            end
            TX_SEND: begin
                if (half_end) begin
                    if (hidx_q == LAST_FRAME_H) begin
                        if (key_held) begin
                            state_d = TX_GAP;
                            hidx_d  = hidx_q + 1'b1;
                        end else begin
                            state_d  = TX_IDLE;
                            hidx_d   = '0;
                            toggle_d = ~toggle_q;
                        end
                    end else begin
                        hidx_d = hidx_q + 1'b1;
                    end
                end
            end
            TX_GAP: begin
                if (!key_held) begin
                    state_d  = TX_IDLE;
                    hidx_d   = '0;
                    toggle_d = ~toggle_q;
                end else if (half_end) begin
                    if (hidx_q == LAST_PERIOD_H) begin
                        state_d = TX_SEND;
                        hidx_d  = '0;
                        frame_d = {2'b11, toggle_q, sys_num, cmd_num};
                    end else begin
                        hidx_d = hidx_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = TX_IDLE;
                hidx_d  = '0;
            end
        endcase
    end

    always_comb begin
        sending  = (state_q == TX_SEND);
        busy     = (state_q != TX_IDLE);
        data_oe  = busy;
        mod_oe   = busy;
        data_out = level;
        mod_out  = level & car_hi;
    end

    // R1: an idle block drives no data.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> (!data_out && !mod_out));
    // R4: carrier only ever gates the baseband level.
    assert_mod_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> data_out);
    // R7: a frame cannot stop before a half-bit boundary.
    assert_frame_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && !half_end) |=> (state_q == TX_SEND));
    // R8: release in the gap ends activity on the next clock.
    assert_gap_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_GAP && !key_held) |=> (state_q == TX_IDLE));
    // R9: the toggle bit moves only on a return to idle.
    assert_toggle_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_q != $past(toggle_q)) |-> (state_q == TX_IDLE && $past(state_q) != TX_IDLE));
    // R6: the half-bit index stays inside the repeat period.
    assert_index_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hidx_q <= LAST_PERIOD_H);
endmodule

// File: tb/sim_irtx_biphase_tx.sv
module sim_irtx_biphase_tx;
    localparam int SYS_W  = 5;
    localparam int CMD_W  = 6;
    localparam int HALF   = 8;
    localparam int REP    = 20;
    localparam int DIV    = 12;
    localparam int HIGH   = 3;
    localparam int FBITS  = 3 + SYS_W + CMD_W;
    localparam int FRAME_CLKS  = 2 * FBITS * HALF;
    localparam int PERIOD_CLKS = 2 * REP * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic code_valid = 1'b0;
    logic key_held = 1'b0;
    logic [SYS_W-1:0] sys_num = '0;
    logic [CMD_W-1:0] cmd_num = '0;
    logic data_out, data_oe, mod_out, mod_oe, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    bit m_busy = 1'b0;
    int m_t = 0;
    bit m_tog = 1'b0;
    logic [FBITS-1:0] m_frame = '0;

    always #4 clk = ~clk;

    irtx_biphase_tx #(
        .SYS_W(SYS_W), .CMD_W(CMD_W), .HALF_CLKS(HALF),
        .REP_BITS(REP), .CAR_DIV(DIV), .CAR_HIGH(HIGH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .key_held(key_held),
        .sys_num(sys_num), .cmd_num(cmd_num), .data_out(data_out), .data_oe(data_oe),
        .mod_out(mod_out), .mod_oe(mod_oe), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    // Behavioural model: time since frame start drives everything.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 1'b0; m_t = 0; m_tog = 1'b0;
        end else if (!m_busy) begin
            if (code_valid) begin
                m_busy = 1'b1; m_t = 0;
                m_frame = {2'b11, m_tog, sys_num, cmd_num};
            end
        end else if (m_t < FRAME_CLKS) begin
            if (m_t == FRAME_CLKS - 1 && !key_held) begin
                m_busy = 1'b0; m_tog = !m_tog;
            end else begin
                m_t++;
            end
        end else if (!key_held) begin
            m_busy = 1'b0; m_tog = !m_tog;
        end else if (m_t == PERIOD_CLKS - 1) begin
            m_t = 0;
            m_frame = {2'b11, m_tog, sys_num, cmd_num};
        end else begin
            m_t++;
        end
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        int hi;
        bit b, lvl, car;
        if (rst_n && !done) begin
            lvl = 1'b0; car = 1'b0;
            if (m_busy && m_t < FRAME_CLKS) begin
                hi  = m_t / HALF;
                b   = m_frame[FBITS - 1 - hi / 2];
                lvl = (hi % 2 == 1) ? b : !b;
                car = ((m_t % HALF) % DIV) < HIGH;
            end
            check("R5 busy", busy, m_busy);
            check("R5 data_oe", data_oe, m_busy);
            check("R5 mod_oe", mod_oe, m_busy);
            check("R2/R3 data_out", data_out, lvl);
            check("R4 mod_out", mod_out, lvl & car);
        end
    end

    task automatic press(input logic [SYS_W-1:0] s, input logic [CMD_W-1:0] c);
        @(negedge clk);
        sys_num = s; cmd_num = c; key_held = 1'b1; code_valid = 1'b1;
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check("R1 busy", busy, 0);
        check("R1 data_oe", data_oe, 0);
        check("R1 mod_oe", mod_oe, 0);
        check("R1 data_out", data_out, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Press 1: held over repeats; inputs change mid-frame (R10) and are used at the repeat (R6).
        press(5'h15, 6'h2A);
        repeat (30) @(negedge clk);
        code_valid = 1'b1; sys_num = 5'h0A; cmd_num = 6'h11;   // R10: ignored now
        @(negedge clk);
        code_valid = 1'b0;
        repeat (2 * PERIOD_CLKS + FRAME_CLKS + 20) @(negedge clk);
        // R8: release in the gap, idle on the next clock
        key_held = 1'b0;
        @(negedge clk);
        check("R8 idle after gap release", busy, 0);
        repeat (10) @(negedge clk);

        // Press 2: release mid-frame; frame completes (R7); toggle is 1 now (R9)
        press(5'h1F, 6'h00);
        // R9: second half of bit 2 (toggle) sits at t = 5*HALF..6*HALF-1
        repeat (5 * HALF + 2 - 1) @(negedge clk);
        check("R9 toggle bit sent as 1", data_out, 1);
        repeat (20) @(negedge clk);
        key_held = 1'b0;
        repeat (40) @(negedge clk);
        check("R7 frame continues after release", busy, 1);
        repeat (FRAME_CLKS) @(negedge clk);
        check("R7 idle after frame", busy, 0);

        // Press 3: other pattern, toggle back to 0 (R9); short hold
        press(5'h00, 6'h3F);
        repeat (FRAME_CLKS + 40) @(negedge clk);
        key_held = 1'b0;
        repeat (20) @(negedge clk);

        // Press 4: alternating pattern, released exactly at frame end
        press(5'h0B, 6'h15);
        repeat (FRAME_CLKS - 3) @(negedge clk);
        key_held = 1'b0;
        repeat (30) @(negedge clk);
        check("R7 idle after final frame", busy, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end
endmodule